// File: doc/BRIEF.md
# PCI configuration header register file

This block holds the 64-byte type-0 configuration header of one PCI function and serves it through a simple request/response port. A request carries a byte offset, an access size in bytes, a write enable and write data. Every request produces exactly one response after a fixed, parameterised number of cycles. The response carries read data and an error flag. Identity values and the sizes of the six base address registers are fixed at elaboration through parameters. The command, cache-line size, latency timer, interrupt line and expansion ROM fields are writable.

The host discovers how much space a base address register needs by writing all ones to it and reading the size mask back. It then programs the base. Once a register holds a nonzero base, the block presents a decode window on its outputs: the programmed base plus a fixed I/O or memory space offset, together with a valid flag. The block marks each such update with a one-cycle range-change pulse, so that the surrounding address decoder can reload its windows.

Top module: `pci_cfg_hdr`

## Requirements
- R1: A read returns `size_i` bytes (1, 2 or 4) starting at `addr_i`, least significant byte from the lowest offset, at any alignment. Bytes past offset 0x3F read as zero. The header layout is:
  - 0x00 vendor ID and 0x02 device ID (16 bits each).
  - 0x04 command and 0x06 status (16 bits each).
  - 0x08 revision, then 0x09–0x0B class code (24 bits).
  - 0x0C cache-line size, 0x0D latency timer, 0x0E header type (zero) and 0x0F self-test byte (zero).
  - 0x10–0x27 six base address registers, 4 bytes each.
  - 0x2C subsystem vendor ID and 0x2E subsystem ID.
  - 0x30 expansion ROM base.
  - 0x3C interrupt line, 0x3D interrupt pin, 0x3E minimum grant and 0x3F maximum latency.
  - All other bytes read as zero.
- R2: An access whose size is not 1, 2 or 4 gets a response with `rsp_err_o`=1 and read data zero, and changes no state.
- R3: An access at offset 0x40 or above gets a response with `rsp_err_o`=1 and read data zero, and changes no state.
- R4: Each request gets exactly one response, with `rsp_valid_o` high for one cycle, RSP_LAT cycles after the clock edge that samples the request. Requests may arrive back to back. A write response carries read data zero and, unless rejected, `rsp_err_o`=0.
- R5: Bit 0 of a base address register reads 1 for an I/O register and 0 for a memory register. Its low 2 bits (I/O) or low 4 bits (memory) are read-only: they read 01 or 0000.
- R6: A 4-byte write of 0xFFFFFFFF to a base address register makes it read ~(size−1) with its read-only low bits replaced by its type bits. It raises no range-change pulse and leaves the decode window unchanged.
- R7: Any other aligned 4-byte write to a base address register replaces its writable bits. If those bits are nonzero, the block does three things in the cycle after the request edge: the decode window becomes those bits plus IO_BASE or MEM_BASE, the valid flag rises, and `range_chg_o` pulses for one cycle. If those bits are zero, the window, the valid flag and the pulse are unaffected. A valid flag never falls.
- R8: A 4-byte write of 0xFFFFFFFE at 0x30 makes the expansion ROM base read 0xFFFFFFFF. Any other 4-byte value there is stored as written.
- R9: A 1-byte write at 0x0C, 0x0D or 0x3C updates only that byte. A 1-byte write to any other offset is ignored without error. This includes interrupt pin, minimum grant, maximum latency, class code and revision.
- R10: A 2- or 4-byte write at 0x04 replaces the 16-bit command field, and the status field is unchanged. A 4-byte write to any other offset that is not a base address register or the expansion ROM base is ignored without error.
- R11: After reset the following hold:
  - command, cache-line size, latency timer and ROM base read 0;
  - interrupt line reads INT_LINE_INIT;
  - base address registers read only their type bits;
  - all window valid flags, `range_chg_o` and `rsp_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset into configuration space |
| size_i | input | 3 | Access size in bytes |
| wdata_i | input | 32 | Write data, little-endian from the offset |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Access was rejected |
| rsp_rdata_o | output | 32 | Read data |
| win_base_o | output | NUM_BARS×32 | Decode window base per base address register |
| win_valid_o | output | NUM_BARS | Decode window programmed |
| range_chg_o | output | 1 | One-cycle pulse when a decode window is updated |

## Verification
Two functions can coincide in one cycle: the range-change pulse and window update from a base address register write, and the delayed response of the read issued just before it. The bench provokes this by issuing a read directly followed by a programming write, and by reading a register in the cycle right after writing it. The judge is a behavioural model that predicts, on every cycle, the response strobe, error flag and data, the pulse and each window. A stale read or a pulse or window off by one cycle therefore shows up as a mismatch.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int NUM_BARS  = 6;
  localparam int HDR_BYTES = 64;  // device-specific space begins here
  localparam int HDR_AW    = $clog2(HDR_BYTES);

  localparam int OFF_CMD   = 'h04;
  localparam int OFF_CLS   = 'h0C;
  localparam int OFF_LAT   = 'h0D;
  localparam int OFF_BAR0  = 'h10;
  localparam int OFF_ROM   = 'h30;
  localparam int OFF_ILINE = 'h3C;

  typedef struct packed {
    logic        err;
    logic [31:0] data;
  } rsp_t;

  function automatic logic size_ok(logic [2:0] s);
    return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
  endfunction
endpackage

// File: rtl/pci_cfg_bar.sv
module pci_cfg_bar #(
  parameter bit          IS_IO      = 1'b0,
  parameter logic [31:0] SIZE       = 32'h1000,
  parameter logic [31:0] SPACE_BASE = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] bar_o,
  output logic [31:0] win_base_o,
  output logic        win_valid_o,
  output logic        chg_o
);
  localparam logic [31:0] TMASK = IS_IO ? 32'h3 : 32'hF;
  localparam logic [31:0] TBITS = IS_IO ? 32'h1 : 32'h0;
  localparam logic [31:0] PROBE = ~(SIZE - 32'd1) & ~TMASK;

  logic [31:0] addr_q;
  logic [31:0] wr_addr;

  assign wr_addr = wdata_i & ~TMASK;
  assign bar_o   = addr_q | TBITS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      win_base_o  <= '0;
      win_valid_o <= 1'b0;
      chg_o       <= 1'b0;
    end else begin
      chg_o <= 1'b0;
      if (wr_i) begin
        if (wdata_i == 32'hFFFF_FFFF) begin
          addr_q <= PROBE;
        end else begin
          addr_q <= wr_addr;
          if (wr_addr != '0) begin
            win_base_o  <= wr_addr + SPACE_BASE;
            win_valid_o <= 1'b1;
            chg_o       <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pci_cfg_rsp_pipe.sv
module pci_cfg_rsp_pipe
  import pci_cfg_pkg::*;
#(
  parameter int unsigned LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  rsp_t rsp_i,
  output logic vld_o,
  output rsp_t rsp_o
);
  logic [LAT-1:0] vld_q;
  rsp_t [LAT-1:0] rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rsp_q <= '0;
    end else begin
      vld_q[0] <= vld_i;
      rsp_q[0] <= vld_i ? rsp_i : '0;
      for (int s = 1; s < int'(LAT); s++) begin
        vld_q[s] <= vld_q[s-1];
        rsp_q[s] <= rsp_q[s-1];
      end
    end
  end

  assign vld_o = vld_q[LAT-1];
  assign rsp_o = rsp_q[LAT-1];
endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
  import pci_cfg_pkg::*;
#(
  parameter int unsigned                  RSP_LAT       = 2,
  parameter logic [15:0]                  VENDOR_ID     = 16'h1AB4,
  parameter logic [15:0]                  DEVICE_ID     = 16'h0001,
  parameter logic [15:0]                  STATUS_VAL    = 16'h0000,
  parameter logic [7:0]                   REVISION      = 8'h00,
  parameter logic [23:0]                  CLASS_CODE    = 24'h000000,
  parameter logic [15:0]                  SUBSYS_VENDOR = 16'h0000,
  parameter logic [15:0]                  SUBSYS_ID     = 16'h0000,
  parameter logic [7:0]                   INT_LINE_INIT = 8'h00,
  parameter logic [7:0]                   INT_PIN       = 8'h01,
  parameter logic [7:0]                   MIN_GNT       = 8'h00,
  parameter logic [7:0]                   MAX_LAT       = 8'h00,
  parameter logic [NUM_BARS-1:0]          BAR_IS_IO     = '0,
  parameter logic [NUM_BARS-1:0][31:0]    BAR_SIZE      = {NUM_BARS{32'h0000_1000}},
  parameter logic [31:0]                  IO_BASE       = 32'h0,
  parameter logic [31:0]                  MEM_BASE      = 32'h0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [7:0]                   addr_i,
  input  logic [2:0]                   size_i,
  input  logic [31:0]                  wdata_i,
  output logic                         rsp_valid_o,
  output logic                         rsp_err_o,
  output logic [31:0]                  rsp_rdata_o,
  output logic [NUM_BARS-1:0][31:0]    win_base_o,
  output logic [NUM_BARS-1:0]          win_valid_o,
  output logic                         range_chg_o
);
  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, line_q;
  logic [31:0] rom_q;

  logic [NUM_BARS-1:0][31:0] bar_val;
  logic [NUM_BARS-1:0]       bar_wr, bar_chg;

  logic acc_err, wr_ok;
  logic [HDR_BYTES-1:0][7:0] hdr;
  logic [31:0] rd_data;
  rsp_t rsp_in, rsp_out;

  assign acc_err = !size_ok(size_i) || (int'(addr_i) >= HDR_BYTES);
  assign wr_ok   = req_i && we_i && !acc_err;

  // header image
  always_comb begin
    hdr        = '0;
    hdr[1:0]   = VENDOR_ID;
    hdr[3:2]   = DEVICE_ID;
    hdr[5:4]   = cmd_q;
    hdr[7:6]   = STATUS_VAL;
    hdr[8]     = REVISION;
    hdr[11:9]  = CLASS_CODE;
    hdr[12]    = cls_q;
    hdr[13]    = lat_q;
    for (int b = 0; b < NUM_BARS; b++) hdr[OFF_BAR0 + 4*b +: 4] = bar_val[b];
    hdr[45:44] = SUBSYS_VENDOR;
    hdr[47:46] = SUBSYS_ID;
    hdr[51:48] = rom_q;
    hdr[60]    = line_q;
    hdr[61]    = INT_PIN;
    hdr[62]    = MIN_GNT;
    hdr[63]    = MAX_LAT;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(size_i) && (int'(addr_i) + i) < HDR_BYTES)
        rd_data[8*i +: 8] = hdr[HDR_AW'(int'(addr_i) + i)];
    end
  end

  // writable scalar fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      cls_q  <= '0;
      lat_q  <= '0;
      line_q <= INT_LINE_INIT;
      rom_q  <= '0;
    end else if (wr_ok) begin
      if ((size_i == 3'd4 || size_i == 3'd2) && int'(addr_i) == OFF_CMD) cmd_q <= wdata_i[15:0];
      if (size_i == 3'd1 && int'(addr_i) == OFF_CLS)   cls_q  <= wdata_i[7:0];
      if (size_i == 3'd1 && int'(addr_i) == OFF_LAT)   lat_q  <= wdata_i[7:0];
      if (size_i == 3'd1 && int'(addr_i) == OFF_ILINE) line_q <= wdata_i[7:0];
      if (size_i == 3'd4 && int'(addr_i) == OFF_ROM)
        rom_q <= (wdata_i == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wdata_i;
    end
  end

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    assign bar_wr[b] = wr_ok && size_i == 3'd4 && int'(addr_i) == OFF_BAR0 + 4*b;
    pci_cfg_bar #(
      .IS_IO      (BAR_IS_IO[b]),
      .SIZE       (BAR_SIZE[b]),
      .SPACE_BASE (BAR_IS_IO[b] ? IO_BASE : MEM_BASE)
    ) u_bar (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (bar_wr[b]),
      .wdata_i     (wdata_i),
      .bar_o       (bar_val[b]),
      .win_base_o  (win_base_o[b]),
      .win_valid_o (win_valid_o[b]),
      .chg_o       (bar_chg[b])
    );
  end

  assign range_chg_o = |bar_chg;

  assign rsp_in.err  = acc_err;
  assign rsp_in.data = (we_i || acc_err) ? 32'h0 : rd_data;

  pci_cfg_rsp_pipe #(.LAT(RSP_LAT)) u_rsp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (req_i),
    .rsp_i  (rsp_in),
    .vld_o  (rsp_valid_o),
    .rsp_o  (rsp_out)
  );

  assign rsp_err_o   = rsp_out.err;
  assign rsp_rdata_o = rsp_out.data;
endmodule

// File: rtl/pci_cfg_hdr_chk.sv
module pci_cfg_hdr_chk
  import pci_cfg_pkg::*;
#(
  parameter int unsigned RSP_LAT = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [7:0]          addr_i,
  input logic [2:0]          size_i,
  input logic [31:0]         wdata_i,
  input logic                rsp_valid_o,
  input logic                rsp_err_o,
  input logic [NUM_BARS-1:0] win_valid_o,
  input logic                range_chg_o
);
  logic [RSP_LAT-1:0] req_sh, bad_sh;
  logic bad_now;

  assign bad_now = !(size_i == 3'd1 || size_i == 3'd2 || size_i == 3'd4) || addr_i >= 8'h40;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sh <= '0;
      bad_sh <= '0;
    end else begin
      req_sh <= {req_sh, req_i};
      bad_sh <= {bad_sh, req_i && bad_now};
    end
  end

  // R4
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == req_sh[RSP_LAT-1]);

  // R2 R3
  err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_err_o == bad_sh[RSP_LAT-1]));

  // R7
  chg_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_chg_o |-> $past(req_i && we_i && size_i == 3'd4 && addr_i >= 8'h10 && addr_i <= 8'h24));

  // R7
  win_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(win_valid_o) & ~win_valid_o) == '0));

  // R7
  win_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(win_valid_o) |-> range_chg_o);

  // R6
  probe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && we_i && size_i == 3'd4 && wdata_i == 32'hFFFF_FFFF) |-> !range_chg_o);
endmodule

bind pci_cfg_hdr pci_cfg_hdr_chk #(.RSP_LAT(RSP_LAT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .size_i      (size_i),
  .wdata_i     (wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .win_valid_o (win_valid_o),
  .range_chg_o (range_chg_o)
);

// File: tb/tb_pci_cfg_hdr.sv
`timescale 1ns/1ps
module tb_pci_cfg_hdr;
  localparam int unsigned LAT = 2;
  localparam int NB = 6;
  localparam logic [31:0] IOB = 32'h8000_0000;
  localparam logic [31:0] MEMB = 32'h4000_0000;
  localparam logic [NB-1:0] IS_IO = 6'b000010;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [2:0] size = '0;
  logic [31:0] wdata = '0;
  logic rsp_valid_o, rsp_err_o, range_chg_o;
  logic [31:0] rsp_rdata_o;
  logic [NB-1:0][31:0] win_base_o;
  logic [NB-1:0] win_valid_o;

  always #2 clk = ~clk;

  pci_cfg_hdr #(
    .RSP_LAT(LAT), .VENDOR_ID(16'h1AB4), .DEVICE_ID(16'h7C21), .STATUS_VAL(16'h0290),
    .REVISION(8'h03), .CLASS_CODE(24'h020000), .SUBSYS_VENDOR(16'h1AB4), .SUBSYS_ID(16'h0011),
    .INT_LINE_INIT(8'h0A), .INT_PIN(8'h01), .MIN_GNT(8'h04), .MAX_LAT(8'h20),
    .BAR_IS_IO(IS_IO),
    .BAR_SIZE({32'h10, 32'h10, 32'h10, 32'h0010_0000, 32'h100, 32'h1000}),
    .IO_BASE(IOB), .MEM_BASE(MEMB)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
    .win_base_o(win_base_o), .win_valid_o(win_valid_o), .range_chg_o(range_chg_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model
  logic [7:0]  m [64];
  logic [31:0] bsz [NB];
  logic [31:0] m_win [NB];
  logic        m_wv [NB];
  logic        exp_chg = 1'b0;
  int          due_q [$];
  logic        err_q [$];
  logic [31:0] dat_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) m[a+i] = v[8*i +: 8];
  endtask

  task automatic model_init();
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    put32(0, 32'h7C21_1AB4);
    put32(4, 32'h0290_0000);
    put32(8, 32'h0200_0003);
    put32('h2C, 32'h0011_1AB4);
    put32('h3C, 32'h2004_010A);
    bsz[0] = 32'h1000; bsz[1] = 32'h100; bsz[2] = 32'h0010_0000;
    bsz[3] = 32'h10; bsz[4] = 32'h10; bsz[5] = 32'h10;
    for (int b = 0; b < NB; b++) begin
      put32('h10 + 4*b, IS_IO[b] ? 32'h1 : 32'h0);
      m_win[b] = '0;
      m_wv[b] = 1'b0;
    end
  endtask

  function automatic logic [31:0] mread(input int a, input int s);
    logic [31:0] d = '0;
    for (int i = 0; i < s; i++) if (a + i < 64) d[8*i +: 8] = m[a+i];
    return d;
  endfunction

  task automatic mwrite(input int a, input int s, input logic [31:0] w);
    logic [31:0] tm, tb, v;
    if (s == 1 && (a == 'h0C || a == 'h0D || a == 'h3C)) m[a] = w[7:0];
    if ((s == 2 || s == 4) && a == 4) begin m[4] = w[7:0]; m[5] = w[15:8]; end
    if (s == 4 && a == 'h30) put32('h30, (w == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : w);
    if (s == 4 && a >= 'h10 && a <= 'h24 && (a % 4) == 0) begin
      int b = (a - 'h10) / 4;
      tm = IS_IO[b] ? 32'h3 : 32'hF;
      tb = IS_IO[b] ? 32'h1 : 32'h0;
      if (w == 32'hFFFF_FFFF) v = (~(bsz[b] - 1) & ~tm) | tb;
      else begin
        v = (w & ~tm) | tb;
        if ((w & ~tm) != 0) begin
          m_win[b] = (w & ~tm) + (IS_IO[b] ? IOB : MEMB);
          m_wv[b] = 1'b1;
          exp_chg = 1'b1;
        end
      end
      put32(a, v);
    end
  endtask

  // one cycle: wait for the falling edge and compare every output with the model
  task automatic tick();
    @(negedge clk);
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      chk(rsp_valid_o === 1'b1, {tag_q[0], " valid"}, 32'(rsp_valid_o), 1);
      chk(rsp_err_o === err_q[0], {tag_q[0], " err"}, 32'(rsp_err_o), 32'(err_q[0]));
      chk(rsp_rdata_o === dat_q[0], {tag_q[0], " data"}, rsp_rdata_o, dat_q[0]);
      void'(due_q.pop_front()); void'(err_q.pop_front());
      void'(dat_q.pop_front()); void'(tag_q.pop_front());
    end else begin
      chk(rsp_valid_o === 1'b0, "R4 idle", 32'(rsp_valid_o), 0);
    end
    chk(range_chg_o === exp_chg, "R7 pulse", 32'(range_chg_o), 32'(exp_chg));
    exp_chg = 1'b0;
    for (int b = 0; b < NB; b++) begin
      chk(win_valid_o[b] === m_wv[b], "R7 valid", 32'(win_valid_o[b]), 32'(m_wv[b]));
      if (m_wv[b]) chk(win_base_o[b] === m_win[b], "R7 window", win_base_o[b], m_win[b]);
    end
  endtask

  task automatic acc(input bit w, input int a, input int s, input logic [31:0] d, input string tag);
    bit bad = !(s == 1 || s == 2 || s == 4) || a >= 64;
    due_q.push_back(cyc + int'(LAT));
    err_q.push_back(bad);
    dat_q.push_back((w || bad) ? 32'h0 : mread(a, s));
    tag_q.push_back(tag);
    if (w && !bad) mwrite(a, s, d);
    req = 1'b1; we = w; addr = 8'(a); size = 3'(s); wdata = d;
    tick();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int s, input logic [31:0] exp, input string tag);
    acc(0, a, s, 0, tag);
    repeat (LAT - 1) tick();
    chk(rsp_valid_o === 1'b1 && rsp_err_o === 1'b0 && rsp_rdata_o === exp, tag, rsp_rdata_o, exp);
  endtask

  task automatic err_chk(input bit w, input int a, input int s, input string tag);
    acc(w, a, s, 32'h1234, tag);
    repeat (LAT - 1) tick();
    chk(rsp_valid_o === 1'b1 && rsp_err_o === 1'b1, tag, 32'(rsp_err_o), 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    // R11 reset state
    chk(rsp_valid_o === 1'b0 && range_chg_o === 1'b0 && win_valid_o === '0, "R11 idle outputs",
        {rsp_valid_o, range_chg_o, 24'h0, win_valid_o}, 0);
    rd_chk('h04, 2, 32'h0000_0000, "R11 command");
    rd_chk('h30, 4, 32'h0000_0000, "R11 rom");
    rd_chk('h3C, 1, 32'h0000_000A, "R11 int line");
    rd_chk('h10, 4, 32'h0000_0000, "R5 mem bar type");
    rd_chk('h14, 4, 32'h0000_0001, "R5 io bar type");
    // R1 identity and alignment
    rd_chk('h00, 4, 32'h7C21_1AB4, "R1 ids");
    rd_chk('h01, 2, 32'h0000_211A, "R1 unaligned");
    rd_chk('h08, 4, 32'h0200_0003, "R1 class rev");
    rd_chk('h2C, 4, 32'h0011_1AB4, "R1 subsystem");
    rd_chk('h3E, 4, 32'h0000_2004, "R1 tail bytes");
    // R2 bad size
    err_chk(1, 'h04, 3, "R2 write size3");
    err_chk(0, 'h00, 0, "R2 read size0");
    rd_chk('h04, 2, 32'h0000_0000, "R2 no side effect");
    // R3 device-specific region
    err_chk(1, 'h40, 4, "R3 write 0x40");
    err_chk(0, 'hFC, 1, "R3 read 0xFC");
    rd_chk('h3F, 1, 32'h0000_0020, "R3 last byte ok");
    // R6 probing
    acc(1, 'h10, 4, 32'hFFFF_FFFF, "R6 probe bar0");
    rd_chk('h10, 4, 32'hFFFF_F000, "R6 mem size mask");
    acc(1, 'h14, 4, 32'hFFFF_FFFF, "R6 probe bar1");
    rd_chk('h14, 4, 32'hFFFF_FF01, "R6 io size mask");
    acc(1, 'h18, 4, 32'hFFFF_FFFF, "R6 probe bar2");
    rd_chk('h18, 4, 32'hFFF0_0000, "R6 large size mask");
    // R7 programming, overlapping a pending read response
    acc(0, 'h00, 4, 0, "R4 back to back read");
    acc(1, 'h10, 4, 32'h1234_5678, "R7 program bar0");
    rd_chk('h10, 4, 32'h1234_5670, "R7 bar0 readback");
    acc(1, 'h14, 4, 32'h0000_ABCF, "R7 program bar1");
    rd_chk('h14, 4, 32'h0000_ABCD, "R5 io low bits kept");
    chk(win_base_o[1] === 32'h8000_ABCC, "R7 io window", win_base_o[1], 32'h8000_ABCC);
    chk(win_base_o[0] === 32'h5234_5670, "R7 mem window", win_base_o[0], 32'h5234_5670);
    acc(1, 'h1C, 4, 32'h0000_000F, "R7 zero base bar3");
    rd_chk('h1C, 4, 32'h0000_0000, "R7 zero base readback");
    acc(1, 'h10, 4, 32'h0000_0000, "R7 clear bar0 keeps window");
    tick();
    chk(win_valid_o[0] === 1'b1 && win_base_o[0] === 32'h5234_5670, "R7 window held",
        win_base_o[0], 32'h5234_5670);
    acc(1, 'h24, 4, 32'hA000_0000, "R7 program bar5");
    acc(1, 'h20, 4, 32'h0000_0100, "R7 program bar4");
    acc(1, 'h12, 4, 32'hFFFF_0000, "R10 unaligned bar write ignored");
    // R8 ROM
    acc(1, 'h30, 4, 32'hFFFF_FFFE, "R8 rom probe");
    rd_chk('h30, 4, 32'hFFFF_FFFF, "R8 rom probe readback");
    acc(1, 'h30, 4, 32'h000C_0001, "R8 rom value");
    rd_chk('h30, 4, 32'h000C_0001, "R8 rom stored");
    // R9 byte fields
    acc(1, 'h3C, 1, 32'h0000_00A5, "R9 int line");
    acc(1, 'h3D, 1, 32'h0000_00FF, "R9 int pin ignored");
    acc(1, 'h3E, 1, 32'h0000_00FF, "R9 min gnt ignored");
    acc(1, 'h0B, 1, 32'h0000_00FF, "R9 class ignored");
    acc(1, 'h08, 1, 32'h0000_00FF, "R9 revision ignored");
    rd_chk('h3C, 4, 32'h2004_01A5, "R9 line only");
    rd_chk('h08, 4, 32'h0200_0003, "R9 identity kept");
    acc(1, 'h0C, 1, 32'h0000_0010, "R9 cache line");
    acc(1, 'h0D, 1, 32'h0000_0040, "R9 latency");
    rd_chk('h0C, 4, 32'h0000_4010, "R9 cls lat");
    // R10 command
    acc(1, 'h04, 4, 32'hFFFF_0147, "R10 command 32");
    rd_chk('h04, 4, 32'h0290_0147, "R10 status kept");
    acc(1, 'h04, 2, 32'h0000_0006, "R10 command 16");
    rd_chk('h04, 2, 32'h0000_0006, "R10 command 16 readback");
    acc(1, 'h00, 4, 32'hDEAD_BEEF, "R10 ro write no err");
    acc(1, 'h2C, 4, 32'hDEAD_BEEF, "R10 subsystem write no err");
    rd_chk('h00, 4, 32'h7C21_1AB4, "R10 ids kept");
    rd_chk('h2C, 4, 32'h0011_1AB4, "R10 subsystem kept");
    // R4 back-to-back burst
    for (int k = 0; k < 8; k++) acc(0, 4 * k, 4, 0, "R4 burst");
    repeat (LAT + 2) tick();
    chk(due_q.size() == 0, "R4 all responses", due_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule